// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the sampling tick of a UART from a fast peripheral clock. Software supplies a 16-bit unsigned fixed-point divisor with twelve integer bits above four bits of sixteenths. The divisor is the number of input clocks per oversample tick. For the usual 16x oversampling the word is the clock frequency over the baud rate, rounded to nearest. For example, 16 MHz at 9600 baud gives 1667 (0x683), a divider of 104.1875. If rounding the fraction reaches a full sixteen sixteenths, the excess is carried into the integer field, so 50.99 becomes 51 with no fraction.

Each tick interval is either the integer part or one clock longer. The longer interval is taken whenever adding the fraction into a small accumulator overflows. Tick spacing is therefore irregular, but the long-run average equals the programmed value. An 8x mode halves the ticks per bit and reads only the low three fraction bits, as eighths. A second output strobes once per bit, together with the last oversample tick of that bit.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `os_tick` and `bit_strobe` are low.
- R2: Every interval between consecutive ticks lasts either the integer part `divisor[15:4]` or that value plus one input clock. The first tick after a restart comes after exactly the integer part of enabled clock edges. An integer part of 1 with fraction 0 gives a tick on every clock.
- R3: In 16x mode (`mode_x8`=0), counting enabled edges from a restart, the k-th tick follows edge k*I + floor((k-1)*F/16). Here I is `divisor[15:4]` and F is `divisor[3:0]`.
- R4: In 8x mode (`mode_x8`=1), the k-th tick follows edge k*I + floor((k-1)*F/8). Here F is `divisor[2:0]`, and `divisor[3]` has no effect on tick timing.
- R5: `bit_strobe` is high together with every 16th tick after a restart in 16x mode, or every 8th tick in 8x mode, and never without a tick.
- R6: An integer part of zero suppresses both outputs for as long as it is applied.
- R7: With `en` low at a clock edge, no tick follows that edge and the sequence restarts.
- R8: A clock edge at which `divisor` or `mode_x8` differs from its value at the previous edge is a restart: no tick follows it, and counting begins again from zero. The first edge after reset is always a restart.
- R9: Over 384 ticks in 16x mode with divisor 0x683, the number of enabled edges up to the last tick is within one clock of 384 × 1667 / 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Tick generation enable |
| divisor | input | 16 | Q12.4 divisor word |
| mode_x8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| os_tick | output | 1 | Oversample tick, one clock wide |
| bit_strobe | output | 1 | Once-per-bit strobe, coincident with a tick |

## Verification
Both outputs are registered. A tick caused by the count reaching its target at a given clock edge is visible from just after that edge until the next edge. A restart caused by `en`, a new divisor or a new mode takes effect at the first edge where the bench presents it. The bench changes inputs only at falling edges. At each rising edge it advances its closed-form model of the due tick times from the inputs it applied. It compares both outputs at the following falling edge, so every result is checked in the single cycle it is due.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    localparam int OS_FULL = 16;
    localparam int OS_HALF = 8;
    localparam int PH_W    = $clog2(OS_FULL);
endpackage

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    localparam int INT_W = DIV_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              mode_x8,
    output logic              run,
    output logic [INT_W-1:0]  int_part,
    output logic [FRAC_W-1:0] frac_eff
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             x8;
    } cfg_t;

    localparam logic [FRAC_W-1:0] LO_MASK = FRAC_W'((1 << (FRAC_W - 1)) - 1);

    cfg_t cfg_d, cfg_q;
    logic same_cfg;

    always_comb begin
        cfg_d.div = divisor;
        cfg_d.x8  = mode_x8;
        int_part  = divisor[DIV_W-1:FRAC_W];
        frac_eff  = mode_x8 ? (divisor[FRAC_W-1:0] & LO_MASK) : divisor[FRAC_W-1:0];
        same_cfg  = (divisor == cfg_q.div) && (mode_x8 == cfg_q.x8);
        run       = en && same_cfg && (int_part != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    localparam int INT_W = DIV_W - FRAC_W,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode_x8,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_eff,
    output logic              hit,
    output logic              tick
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              ext;
        logic              tick;
    } acc_t;

    localparam logic [FRAC_W-1:0] LO_MASK = FRAC_W'((1 << (FRAC_W - 1)) - 1);
    localparam acc_t ACC_RST = '{cnt: CNT_W'(1), acc: '0, ext: 1'b0, tick: 1'b0};

    acc_t st_d, st_q;
    logic [FRAC_W:0]   sum;
    logic              carry;
    logic [FRAC_W-1:0] acc_nxt;
    logic [CNT_W-1:0]  target;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, frac_eff};
        carry   = mode_x8 ? sum[FRAC_W-1] : sum[FRAC_W];
        acc_nxt = mode_x8 ? (sum[FRAC_W-1:0] & LO_MASK) : sum[FRAC_W-1:0];
        target  = {1'b0, int_part} + CNT_W'(st_q.ext);
        hit     = run && (st_q.cnt == target);

        st_d      = st_q;
        st_d.tick = hit;
        if (!run) begin
            st_d.cnt = CNT_W'(1);
            st_d.acc = '0;
            st_d.ext = 1'b0;
        end else if (hit) begin
            st_d.cnt = CNT_W'(1);
            st_d.acc = acc_nxt;
            st_d.ext = carry;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_RST;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/frac_baud_phase.sv
module frac_baud_phase
    import frac_baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mode_x8,
    input  logic hit,
    output logic strobe
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            strobe;
    } ph_t;

    ph_t ph_d, ph_q;
    logic [PH_W-1:0] last;

    always_comb begin
        last        = mode_x8 ? PH_W'(OS_HALF - 1) : PH_W'(OS_FULL - 1);
        ph_d        = ph_q;
        ph_d.strobe = 1'b0;
        if (!run) begin
            ph_d.ph = '0;
        end else if (hit) begin
            ph_d.strobe = (ph_q.ph == last);
            ph_d.ph     = (ph_q.ph == last) ? '0 : ph_q.ph + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign strobe = ph_q.strobe;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    input  logic             mode_x8,
    output logic             os_tick,
    output logic             bit_strobe
);
    localparam int INT_W = DIV_W - FRAC_W;

    logic              run;
    logic              hit;
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_eff;

    frac_baud_cfg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor), .mode_x8(mode_x8),
        .run(run), .int_part(int_part), .frac_eff(frac_eff)
    );

    frac_baud_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_x8(mode_x8),
        .int_part(int_part), .frac_eff(frac_eff), .hit(hit), .tick(os_tick)
    );

    frac_baud_phase u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_x8(mode_x8),
        .hit(hit), .strobe(bit_strobe)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [DIV_W-1:0] divisor,
    input logic             mode_x8,
    input logic             os_tick,
    input logic             bit_strobe
);
    // R5: strobe only alongside a tick
    p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> os_tick);

    // R7: disabled edge yields no tick
    p_off_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!os_tick && !bit_strobe));

    // R6: zero integer part yields no tick
    p_zero_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(divisor[DIV_W-1:FRAC_W]) == '0) |-> !os_tick);

    // R2: back-to-back ticks only for an integer part of one
    p_min_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && $past(os_tick)) |-> ($past(divisor[DIV_W-1:FRAC_W]) == 1));

    // R8: a divisor change suppresses the tick of that edge
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(divisor) != $past(divisor, 2)) |-> !os_tick);

    // R8: a mode change suppresses the tick of that edge
    p_mode_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_x8) != $past(mode_x8, 2)) |-> !os_tick);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor), .mode_x8(mode_x8),
    .os_tick(os_tick), .bit_strobe(bit_strobe)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] divisor = 16'h0000;
    logic        mode_x8 = 1'b0;
    logic        os_tick, bit_strobe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // model state
    int  m_n, m_k;
    bit  m_first;
    int  p_div;
    bit  p_x8;
    bit  exp_tick, exp_strobe;
    int  obs_ticks;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor),
        .mode_x8(mode_x8), .os_tick(os_tick), .bit_strobe(bit_strobe)
    );

    function automatic int due(int k, int ip, int f, int d);
        return k * ip + ((k - 1) * f) / d;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic step(string tag);
        int ip, f, d, nb;
        bit restart;
        @(posedge clk);
        ip = int'(divisor[15:4]);
        f  = mode_x8 ? int'(divisor[2:0]) : int'(divisor[3:0]);
        d  = mode_x8 ? 8 : 16;
        nb = mode_x8 ? 8 : 16;
        restart = m_first || !en || (int'(divisor) != p_div) || (mode_x8 != p_x8) || (ip == 0);
        m_first = 0;
        p_div = int'(divisor);
        p_x8  = mode_x8;
        exp_tick = 0;
        exp_strobe = 0;
        if (restart) begin
            m_n = 0;
            m_k = 0;
        end else begin
            m_n++;
            if (m_n == due(m_k + 1, ip, f, d)) begin
                m_k++;
                exp_tick = 1;
                exp_strobe = (m_k % nb) == 0;
            end
        end
        @(negedge clk);
        if (os_tick) obs_ticks++;
        check(os_tick == exp_tick, tag, "os_tick", int'(os_tick), int'(exp_tick));
        check(bit_strobe == exp_strobe, tag, "bit_strobe", int'(bit_strobe), int'(exp_strobe));
    endtask

    task automatic run_cycles(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        // R1: reset state
        m_first = 1;
        p_div = 0;
        p_x8 = 0;
        divisor = 16'h0035;
        repeat (4) @(negedge clk);
        check(os_tick == 0 && bit_strobe == 0, "R1", "outputs in reset", int'(os_tick), 0);
        rst_n = 1'b1;
        step("R1");
        check(os_tick == 0 && bit_strobe == 0, "R1", "outputs after reset", int'(os_tick), 0);

        // R2 R3 R5: 16x, integer 3, fraction 5/16
        en = 1'b1;
        run_cycles(2000, "R3");

        // R2: integer 1, fraction 0 -> tick every clock
        divisor = 16'h0010;
        run_cycles(200, "R2");

        // R4: 8x mode, bit 3 set but ignored (fraction 5/8)
        divisor = 16'h003D;
        mode_x8 = 1'b1;
        run_cycles(1000, "R4");
        // same timing with bit 3 clear
        divisor = 16'h0035;
        run_cycles(1000, "R4");
        // R5: 8x strobe with non-trivial integer
        divisor = 16'h0072;
        run_cycles(800, "R5");

        // R8: mode change only
        mode_x8 = 1'b0;
        run_cycles(600, "R8");
        // R8: divisor change mid-sequence
        divisor = 16'h0024;
        run_cycles(300, "R8");
        divisor = 16'h0025;
        run_cycles(300, "R8");

        // R7: enable low, then back
        en = 1'b0;
        run_cycles(50, "R7");
        en = 1'b1;
        run_cycles(300, "R7");

        // R6: zero integer part
        divisor = 16'h000F;
        run_cycles(200, "R6");
        divisor = 16'h0000;
        run_cycles(50, "R6");

        // R9: long-run average over 384 ticks, 16x, 0x683
        divisor = 16'h0683;
        obs_ticks = 0;
        begin
            int steps = 0;
            int n_at = -1;
            while (n_at < 0 && steps < 45000) begin
                step("R9");
                steps++;
                if (obs_ticks == 384) n_at = steps - 1;
            end
            check((n_at >= 0) && (16 * n_at - 384 * 1667 <= 16) && (384 * 1667 - 16 * n_at <= 16),
                  "R9", "edges to 384th tick (x16)", 16 * n_at, 384 * 1667);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule